// File: doc/BRIEF.md
# Bus-Master Device Enumeration Engine for a Single-Wire Bus

This block lets the master of a single-wire, open-drain bus discover the 64-bit registration numbers of every slave attached to it. It sits above a bit-level transceiver that performs three primitive operations: a reset with presence sampling, a one-bit write and a one-bit read. The engine drives that transceiver through a simple request/done handshake. Waveform timing and the CRC check of the returned numbers are handled elsewhere.

Each `start` runs one enumeration pass. A pass resets the bus and sends the search command byte F0h, least significant bit first. It then walks the 64 bit positions. At each position it reads the slaves' bit, reads its complement, and writes the direction it has chosen. Only slaves whose bit matches that direction stay in the search. Because the bus is wired-AND, a position where slaves disagree reads as 0 then 0. The engine remembers the highest such fork at which it took the 0 branch. On the following pass it takes the 1 branch there, so each device is reported exactly once. One pass yields one number, strobed with `rom_valid`. `last_found` rises with the pass that reports the final device.

The controller is a state machine with these states:
- S_IDLE: waiting for `start`.
- S_RESET: reset and presence.
- S_CMD: the eight command-bit writes.
- S_RD_ID: reads the bit.
- S_RD_CMP: reads the complement.
- S_WR_DIR: writes the chosen direction.
- S_END: a one-cycle completion state.

Its transitions are:
- S_IDLE to S_RESET on `start`.
- S_RESET to S_CMD on presence, or to S_END without it.
- S_CMD to S_RD_ID after the eighth bit.
- S_RD_ID to S_RD_CMP.
- S_RD_CMP to S_WR_DIR, or to S_END on a 1/1 pair.
- S_WR_DIR to S_RD_ID, or to S_END after bit 63.
- S_END to S_IDLE.

Top module: `owsrch_engine`

## Requirements
- R1: After reset, `busy`, `pass_done`, `rom_valid`, `bop_req` and `last_found` are all 0.
- R2: A pass issues its operations in a fixed order, 201 in total. First comes one reset operation (`bop_code` 00). Then come eight write operations (`bop_code` 01) carrying F0h least significant bit first, i.e. 0,0,0,0,1,1,1,1. Then, for each bit position 0 to 63, there are two reads (`bop_code` 10) followed by one write. `bop_code` and `bop_wbit` hold steady while `bop_req` waits for `bop_done`.
- R3: When the two reads of a position differ, the engine writes the first read value, and that value becomes the result bit.
- R4: When both reads return 0 (a fork), the engine picks the direction from the fork's 1-based position compared with the recorded last fork. Below the last fork it repeats the bit from the previous result. At the last fork it writes 1. Above it, it writes 0.
- R5: When a pass succeeds, the recorded last fork becomes the highest position at which the engine wrote 0 on a fork. `last_found` is 1 exactly when no such position exists.
- R6: A successful pass ends with a one-cycle `pass_done` with `pass_status` 00 and `rom_valid` 1. `rom_id` holds the 64 chosen bits, bit 0 first on the bus. Successive passes report every device once, then `last_found` rises.
- R7: If both reads of a position return 1, the pass ends at once with `pass_status` 10 and no further bus operation. `rom_valid` stays 0 and `rom_id` keeps its previous value. The recorded fork and `last_found` are cleared, so the next pass starts a fresh enumeration.
- R8: If the reset operation returns `bop_rbit` 0 (no presence), the pass ends with `pass_status` 01 after that single operation, and `rom_valid` stays 0.
- R9: A `start` with `restart` 1, or while `last_found` is 1, begins a fresh enumeration from the first device.
- R10: A `start` raised while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one pass (taken only when idle) |
| restart | input | 1 | With `start`: forget earlier passes |
| busy | output | 1 | A pass is in progress |
| pass_done | output | 1 | One-cycle end-of-pass strobe |
| rom_valid | output | 1 | `pass_done` of a successful pass |
| rom_id | output | 64 | Last successfully found number |
| pass_status | output | 2 | 00 found, 01 no device, 10 no path |
| last_found | output | 1 | The latest number was the final device |
| bop_req | output | 1 | Bit-operation request, held until done |
| bop_code | output | 2 | 00 reset, 01 write, 10 read |
| bop_wbit | output | 1 | Value to write |
| bop_done | input | 1 | One-cycle operation completion |
| bop_rbit | input | 1 | Read value, or presence after a reset |

## Verification
A wrong direction choice inside a pass shows on `bop_wbit` in the write slot of that very triplet. It then shows as a wrong `rom_id` at the end of that pass. A corrupted fork record does not change the current pass. It shows one pass later, as a device reported twice or skipped, or as `last_found` rising too early or never. Sequencing faults change the number or order of bit operations, and show by the `pass_done` of the same pass. Failure to clear state after an abort shows in the following pass's `rom_id`.

// File: rtl/owsrch_pkg.sv
package owsrch_pkg;

    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } bitop_e;

    typedef enum logic [1:0] {
        ST_FOUND  = 2'b00,
        ST_NODEV  = 2'b01,
        ST_NOPATH = 2'b10
    } pass_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RESET,
        S_CMD,
        S_RD_ID,
        S_RD_CMP,
        S_WR_DIR,
        S_END
    } srch_state_e;

endpackage

// File: rtl/owsrch_idreg.sv
// Working register of the bits chosen in the current pass; between passes it
// still holds the previous result, which the fork logic replays.
module owsrch_idreg #(
    parameter int ID_W  = 64,
    localparam int IDX_W = $clog2(ID_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             wr_bit,
    output logic             rd_bit,
    output logic [ID_W-1:0]  value
);

    logic bits_q [ID_W];

    for (genvar g = 0; g < ID_W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q[g] <= 1'b0;
            end else if (wr_en && sel_idx == IDX_W'(g)) begin
                bits_q[g] <= wr_bit;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < ID_W; i++) begin
            value[i] = bits_q[i];
        end
    end

    assign rd_bit = value[sel_idx];

endmodule

// File: rtl/owsrch_fork.sv
// Direction choice and fork bookkeeping across passes.
module owsrch_fork #(
    parameter int ID_W   = 64,
    localparam int DISC_W = $clog2(ID_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              pass_start,
    input  logic              step,
    input  logic              finish,
    input  logic [DISC_W-1:0] pos,
    input  logic              id_bit,
    input  logic              cmp_bit,
    input  logic              prev_bit,
    output logic              dir,
    output logic              last_found
);

    logic [DISC_W-1:0] last_disc_q;
    logic [DISC_W-1:0] last_zero_q;
    logic [DISC_W-1:0] lz_next;
    logic              at_fork;

    assign at_fork = !id_bit && !cmp_bit;

    always_comb begin
        if (!at_fork) begin
            dir = id_bit;
        end else if (pos < last_disc_q) begin
            dir = prev_bit;
        end else if (pos == last_disc_q) begin
            dir = 1'b1;
        end else begin
            dir = 1'b0;
        end
        lz_next = (at_fork && !dir) ? pos : last_zero_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_zero_q <= '0;
        end else if (pass_start) begin
            last_zero_q <= '0;
        end else if (step) begin
            last_zero_q <= lz_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_disc_q <= '0;
            last_found  <= 1'b0;
        end else if (clear) begin
            last_disc_q <= '0;
            last_found  <= 1'b0;
        end else if (finish) begin
            last_disc_q <= lz_next;
            last_found  <= (lz_next == '0);
        end
    end

    // R5
    found_nodisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_found |-> (last_disc_q == '0));

endmodule

// File: rtl/owsrch_engine.sv
module owsrch_engine
    import owsrch_pkg::*;
#(
    parameter int          ID_W     = 64,
    parameter int          CMD_W    = 8,
    parameter logic [CMD_W-1:0] CMD_CODE = 8'hF0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            restart,
    output logic            busy,
    output logic            pass_done,
    output logic            rom_valid,
    output logic [ID_W-1:0] rom_id,
    output logic [1:0]      pass_status,
    output logic            last_found,
    output logic            bop_req,
    output logic [1:0]      bop_code,
    output logic            bop_wbit,
    input  logic            bop_done,
    input  logic            bop_rbit
);

    localparam int IDX_W  = $clog2(ID_W);
    localparam int CNT_W  = $clog2(CMD_W);
    localparam int DISC_W = $clog2(ID_W + 1);

    srch_state_e  state_q, state_d;
    pass_status_e status_q, status_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic id_q, id_d, cmp_q, cmp_d;
    logic [ID_W-1:0] rom_q, rom_next, work_val;
    logic clr, pstart, step, finish;
    logic dir, prev_bit;
    logic [DISC_W-1:0] pos;

    assign pos = DISC_W'(idx_q) + DISC_W'(1);

    owsrch_idreg #(.ID_W(ID_W)) u_idreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (step),
        .sel_idx (idx_q),
        .wr_bit  (dir),
        .rd_bit  (prev_bit),
        .value   (work_val)
    );

    owsrch_fork #(.ID_W(ID_W)) u_fork (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clr),
        .pass_start (pstart),
        .step       (step),
        .finish     (finish),
        .pos        (pos),
        .id_bit     (id_q),
        .cmp_bit    (cmp_q),
        .prev_bit   (prev_bit),
        .dir        (dir),
        .last_found (last_found)
    );

    // Next-state and datapath control
    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        idx_d    = idx_q;
        cnt_d    = cnt_q;
        id_d     = id_q;
        cmp_d    = cmp_q;
        clr      = 1'b0;
        pstart   = 1'b0;
        step     = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    pstart  = 1'b1;
                    clr     = restart || last_found;
                    state_d = S_RESET;
                end
            end
            S_RESET: begin
                if (bop_done) begin
                    if (bop_rbit) begin
                        cnt_d   = '0;
                        state_d = S_CMD;
                    end else begin
                        status_d = ST_NODEV;
                        clr      = 1'b1;
                        state_d  = S_END;
                    end
                end
            end
            S_CMD: begin
                if (bop_done) begin
                    if (cnt_q == CNT_W'(CMD_W - 1)) begin
                        idx_d   = '0;
                        state_d = S_RD_ID;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            S_RD_ID: begin
                if (bop_done) begin
                    id_d    = bop_rbit;
                    state_d = S_RD_CMP;
                end
            end
            S_RD_CMP: begin
                if (bop_done) begin
                    cmp_d = bop_rbit;
                    if (id_q && bop_rbit) begin
                        status_d = ST_NOPATH;
                        clr      = 1'b1;
                        state_d  = S_END;
                    end else begin
                        state_d = S_WR_DIR;
                    end
                end
            end
            S_WR_DIR: begin
                if (bop_done) begin
                    step = 1'b1;
                    if (idx_q == IDX_W'(ID_W - 1)) begin
                        finish   = 1'b1;
                        status_d = ST_FOUND;
                        state_d  = S_END;
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        state_d = S_RD_ID;
                    end
                end
            end
            S_END: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        rom_next          = work_val;
        rom_next[idx_q]   = dir;
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            status_q <= ST_FOUND;
            idx_q    <= '0;
            cnt_q    <= '0;
            id_q     <= 1'b0;
            cmp_q    <= 1'b0;
            rom_q    <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
            idx_q    <= idx_d;
            cnt_q    <= cnt_d;
            id_q     <= id_d;
            cmp_q    <= cmp_d;
            if (finish) begin
                rom_q <= rom_next;
            end
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q != S_IDLE);
        pass_done   = (state_q == S_END);
        rom_valid   = pass_done && (status_q == ST_FOUND);
        rom_id      = rom_q;
        pass_status = status_q;
        bop_req     = 1'b0;
        bop_code    = OP_RESET;
        bop_wbit    = 1'b0;
        unique case (state_q)
            S_RESET: begin
                bop_req  = 1'b1;
                bop_code = OP_RESET;
            end
            S_CMD: begin
                bop_req  = 1'b1;
                bop_code = OP_WRITE;
                bop_wbit = CMD_CODE[cnt_q];
            end
            S_RD_ID, S_RD_CMP: begin
                bop_req  = 1'b1;
                bop_code = OP_READ;
            end
            S_WR_DIR: begin
                bop_req  = 1'b1;
                bop_code = OP_WRITE;
                bop_wbit = dir;
            end
            default: ;
        endcase
    end

    // R2
    bop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bop_req && !bop_done) |=> (bop_req && $stable(bop_code) && $stable(bop_wbit)));

    // R2
    id_then_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_ID && bop_done) |=> (state_q == S_RD_CMP));

    // R7
    nopath_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_CMP && bop_done && id_q && bop_rbit)
            |=> (pass_done && pass_status == ST_NOPATH && !bop_req && !rom_valid));

    // R8
    nodev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RESET && bop_done && !bop_rbit)
            |=> (pass_done && pass_status == ST_NODEV && !rom_valid));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pass_done) |=> busy);

endmodule

// File: tb/owsrch_engine_test.sv
`timescale 1ns/1ps
module owsrch_engine_test;

    localparam int LAT     = 2;
    localparam int NVEC    = 7;
    localparam int MAXDEV  = 8;
    localparam int FULLOPS = 201;

    // bit 65: first of a device set, bit 64: last of the set, then the number
    // expected from that pass (entries are in expected discovery order)
    localparam logic [65:0] VEC [NVEC] = '{
        {2'b10, 64'hA5A5_0000_1234_5600},
        {2'b00, 64'h0F0F_F0F0_0000_0004},
        {2'b00, 64'h1111_2222_3333_0002},
        {2'b01, 64'h8000_0000_0000_0001},
        {2'b11, 64'h0123_4567_89AB_CDEF},
        {2'b10, 64'h0000_0000_0000_0055},
        {2'b01, 64'h8000_0000_0000_0055}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic restart = 1'b0;
    logic busy, pass_done, rom_valid, last_found, bop_req, bop_wbit;
    logic [63:0] rom_id;
    logic [1:0] pass_status, bop_code;
    logic bop_done = 1'b0;
    logic bop_rbit = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    owsrch_engine uut (
        .clk (clk), .rst_n (rst_n), .start (start), .restart (restart),
        .busy (busy), .pass_done (pass_done), .rom_valid (rom_valid),
        .rom_id (rom_id), .pass_status (pass_status), .last_found (last_found),
        .bop_req (bop_req), .bop_code (bop_code), .bop_wbit (bop_wbit),
        .bop_done (bop_done), .bop_rbit (bop_rbit)
    );

    // Slave population behind the bit layer
    logic [63:0] dev_id [MAXDEV];
    int dev_cnt = 0;
    int vanish_at = -1;
    logic [MAXDEV-1:0] act;
    int m_idx, m_ph, wr_cnt, op_cnt, lat;
    logic [7:0] cmd_seen;
    logic seq_ok;

    always @(posedge clk) begin
        if (!rst_n) begin
            bop_done <= 1'b0;
            lat = 0;
            op_cnt = 0;
        end else if (bop_done) begin
            bop_done <= 1'b0;
        end else if (bop_req) begin
            if (lat < LAT) begin
                lat = lat + 1;
            end else begin
                lat = 0;
                bop_done <= 1'b1;
                case (bop_code)
                    2'b00: begin
                        for (int j = 0; j < MAXDEV; j++) act[j] = (j < dev_cnt);
                        m_idx = 0; m_ph = 0; wr_cnt = 0; op_cnt = 1;
                        cmd_seen = 8'h00; seq_ok = 1'b1;
                        bop_rbit <= (dev_cnt != 0);
                    end
                    2'b01: begin
                        op_cnt = op_cnt + 1;
                        if (wr_cnt < 8) begin
                            cmd_seen[wr_cnt] = bop_wbit;
                            wr_cnt = wr_cnt + 1;
                        end else begin
                            if (m_ph != 2 || m_idx > 63) seq_ok = 1'b0;
                            for (int j = 0; j < MAXDEV; j++)
                                if (m_idx < 64 && dev_id[j][m_idx] != bop_wbit) act[j] = 1'b0;
                            m_idx = m_idx + 1;
                            m_ph = 0;
                        end
                        bop_rbit <= 1'b0;
                    end
                    default: begin
                        automatic logic r = 1'b1;
                        op_cnt = op_cnt + 1;
                        if (wr_cnt < 8 || m_ph > 1 || m_idx > 63) seq_ok = 1'b0;
                        if (m_idx == vanish_at) act = '0;
                        for (int j = 0; j < MAXDEV; j++)
                            if (act[j] && m_idx < 64)
                                r = r & ((m_ph == 0) ? dev_id[j][m_idx] : ~dev_id[j][m_idx]);
                        m_ph = m_ph + 1;
                        bop_rbit <= r;
                    end
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act_v, input logic [63:0] exp_v);
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    logic [1:0]  got_status;
    logic        got_valid, got_last, got_req;
    logic [63:0] got_id;

    task automatic run_pass(input logic rs, input logic poke);
        @(negedge clk);
        start = 1'b1; restart = rs;
        @(negedge clk);
        start = 1'b0; restart = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!pass_done) @(negedge clk);
        got_status = pass_status; got_valid = rom_valid; got_id = rom_id;
        got_last = last_found; got_req = bop_req;
    endtask

    task automatic load_devs(input logic [63:0] a, input logic [63:0] b, input int n);
        dev_id[0] = a; dev_id[1] = b; dev_cnt = n;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < MAXDEV; j++) dev_id[j] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 pass_done", 64'(pass_done), 64'd0);
        chk("R1 rom_valid", 64'(rom_valid), 64'd0);
        chk("R1 bop_req", 64'(bop_req), 64'd0);
        chk("R1 last_found", 64'(last_found), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: R2 R3 R4 R5 R6
        for (int k = 0; k < NVEC; k++) begin
            automatic logic rs = 1'b0;
            if (VEC[k][65]) begin
                dev_cnt = 0;
                for (int j = k; j < NVEC; j++) begin
                    dev_id[dev_cnt] = VEC[j][63:0];
                    dev_cnt++;
                    if (VEC[j][64]) break;
                end
                rs = 1'b1;
            end
            run_pass(rs, 1'b0);
            chk("R6 status", 64'(got_status), 64'd0);
            chk("R6 rom_valid", 64'(got_valid), 64'd1);
            chk("R3/R4 rom_id", got_id, VEC[k][63:0]);
            chk("R5 last_found", 64'(got_last), 64'(VEC[k][64]));
            chk("R2 op count", 64'(op_cnt), 64'(FULLOPS));
            chk("R2 command byte", 64'(cmd_seen), 64'hF0);
            chk("R2 op order", 64'(seq_ok), 64'd1);
        end

        // R9: last_found set, start without restart begins again
        run_pass(1'b0, 1'b0);
        chk("R9 rom_id restart", got_id, 64'h0000_0000_0000_0055);
        chk("R9 last_found", 64'(got_last), 64'd0);

        // R10: start while busy ignored
        run_pass(1'b0, 1'b1);
        chk("R10 rom_id", got_id, 64'h8000_0000_0000_0055);
        repeat (3) @(negedge clk);
        chk("R10 busy after done", 64'(busy), 64'd0);
        chk("R10 op count", 64'(op_cnt), 64'(FULLOPS));

        // R7: path vanishes mid-pass, state cleared
        load_devs(64'hA5A5_0000_1234_5600, 64'h0F0F_F0F0_0000_0004, 2);
        run_pass(1'b1, 1'b0);
        chk("R7 pre pass id", got_id, 64'hA5A5_0000_1234_5600);
        vanish_at = 10;
        run_pass(1'b0, 1'b0);
        vanish_at = -1;
        chk("R7 status", 64'(got_status), 64'd2);
        chk("R7 rom_valid", 64'(got_valid), 64'd0);
        chk("R7 rom_id kept", got_id, 64'hA5A5_0000_1234_5600);
        chk("R7 last_found", 64'(got_last), 64'd0);
        chk("R7 op count", 64'(op_cnt), 64'd41);
        chk("R7 no req", 64'(got_req), 64'd0);
        run_pass(1'b0, 1'b0);
        chk("R7 fresh after abort", got_id, 64'hA5A5_0000_1234_5600);

        // R8: no presence
        dev_cnt = 0;
        run_pass(1'b1, 1'b0);
        chk("R8 status", 64'(got_status), 64'd1);
        chk("R8 rom_valid", 64'(got_valid), 64'd0);
        chk("R8 op count", 64'(op_cnt), 64'd1);
        chk("R8 no req", 64'(got_req), 64'd0);
        chk("R8 rom_id kept", got_id, 64'hA5A5_0000_1234_5600);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule